// File: doc/BRIEF.md
# Combined I2C Transfer Sequencer

This block sits between a host that issues I2C messages and the byte engine that moves them on the bus. Each message request carries a stop flag, a direction and a byte count. From the stop flag of the new request and the position of the previous message, the block works out whether the message stands alone or belongs to a chain of messages joined by repeated starts. It then presents that position to the engine.

The block also owns the bus-hold control. Hold is raised when a message opens a transaction, so the engine keeps the bus between messages. Hold is dropped at the point where a STOP may follow. For a read, that point is just after the address goes out. For a write, it is just after the last data byte has been queued. Only the message that ends a transaction releases hold.

An abort input returns everything to the standalone state at once. Requests use a valid/ready handshake. The position and hold outputs are registered.

Top module: `xfer_chain_seq`

## Requirements
- R1: After a synchronous reset, `pos` is 2'b00 (standalone), `hold` is 0 and `req_ready` is 1. The position encoding is 00 standalone, 01 chain-open, 10 chain-middle and 11 chain-close.
- R2: A request accepted while `pos` is standalone gives standalone when `req_stop`=1 and chain-open when `req_stop`=0.
- R3: A request accepted while `pos` is chain-open or chain-middle gives chain-close when `req_stop`=1 and chain-middle when `req_stop`=0.
- R4: A request accepted while `pos` is chain-close gives standalone when `req_stop`=1 and chain-open when `req_stop`=0.
- R5: `pos` takes its new value in the cycle after acceptance. Acceptance is a cycle with `req_valid` and `req_ready` high and `abort` low. `pos` changes at no other time except through abort.
- R6: When the new position is standalone or chain-open, `hold` is 1 in the cycle after acceptance. `hold` never rises at any other time.
- R7: A read whose position is standalone or chain-close drops `hold` in the cycle after `addr_done`.
- R8: A write whose position is standalone or chain-close drops `hold` in the cycle after its `req_len`-th `byte_queued` pulse. If `req_len` is 0, it drops `hold` in the cycle after `addr_done`.
- R9: A message whose position is chain-open or chain-middle ends without changing `hold`.
- R10: `abort` sets `pos` to standalone, clears `hold` and raises `req_ready` in the next cycle. It takes priority over every other input.
- R11: `req_ready` is 0 from the cycle after acceptance until the cycle after the message ends. A `req_valid` pulse while `req_ready` is 0 has no effect on `pos` or `hold`.
- R12: `addr_done` and `byte_queued` have no effect while no message is active. `byte_queued` before `addr_done` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Message request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_stop | input | 1 | Request ends with a STOP |
| req_read | input | 1 | 1 = read message, 0 = write message |
| req_len | input | LEN_W | Data bytes in the message |
| addr_done | input | 1 | Engine has issued the address of the active message |
| byte_queued | input | 1 | Engine has queued one write data byte |
| abort | input | 1 | Stop command: return to standalone and release the bus |
| pos | output | 2 | Position of the current message |
| hold | output | 1 | Bus-hold control to the engine |

## Verification
The hardest case to reach is a chain that passes through every position and then has its last message released by the write-side byte count rather than the address event. The long tail of such a chain is also hard to reach. Random requests use a stop flag weighted toward 0, which builds chains of several middle messages, along with random byte counts including zero and random gaps between engine events. Directed steps add stray engine pulses while idle, byte pulses ahead of the address, `req_valid` pulses while busy, and aborts in the middle of a message.

// File: rtl/xfer_chain_pkg.sv
package xfer_chain_pkg;

  typedef enum logic [1:0] {
    POS_ALONE = 2'b00,
    POS_OPEN  = 2'b01,
    POS_MID   = 2'b10,
    POS_CLOSE = 2'b11
  } pos_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10
  } phase_t;

  // next message position from the current one and the stop flag
  function automatic pos_t pos_step(input pos_t cur, input logic stop);
    pos_t nx;
    case (cur)
      POS_OPEN, POS_MID: nx = stop ? POS_CLOSE : POS_MID;
      POS_CLOSE:         nx = stop ? POS_ALONE : POS_OPEN;
      default:           nx = stop ? POS_ALONE : POS_OPEN;
    endcase
    return nx;
  endfunction

  function automatic logic pos_raises_hold(input pos_t p);
    return (p == POS_ALONE) || (p == POS_OPEN);
  endfunction

  function automatic logic pos_drops_hold(input pos_t p);
    return (p == POS_ALONE) || (p == POS_CLOSE);
  endfunction

endpackage

// File: rtl/xfer_chain_pos.sv
module xfer_chain_pos
  import xfer_chain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic stop,
  input  logic abort,
  output pos_t pos_next,
  output pos_t pos_q
);

  always_comb begin
    pos_next = pos_step(pos_q, stop);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      pos_q <= POS_ALONE;
    end else if (take) begin
      pos_q <= pos_next;
    end
  end

endmodule

// File: rtl/xfer_chain_hold.sv
module xfer_chain_hold
  import xfer_chain_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  pos_t             pos_next,
  input  logic             rd,
  input  logic [LEN_W-1:0] len,
  input  logic             addr_done,
  input  logic             byte_queued,
  input  logic             abort,
  output logic             hold_q,
  output logic             busy_q
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_t           phase_q;
  logic             rd_q;
  logic             rel_q;
  logic [LEN_W-1:0] left_q;
  logic             msg_end;

  // end point of the active message
  always_comb begin
    msg_end = 1'b0;
    case (phase_q)
      PH_ADDR: msg_end = addr_done && (rd_q || (left_q == '0));
      PH_DATA: msg_end = byte_queued && (left_q == ONE);
      default: msg_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      phase_q <= PH_IDLE;
      rd_q    <= 1'b0;
      rel_q   <= 1'b0;
      left_q  <= '0;
      busy_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else if (take) begin
      phase_q <= PH_ADDR;
      rd_q    <= rd;
      rel_q   <= pos_drops_hold(pos_next);
      left_q  <= len;
      busy_q  <= 1'b1;
      if (pos_raises_hold(pos_next)) begin
        hold_q <= 1'b1;
      end
    end else if (msg_end) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
      left_q  <= '0;
      if (rel_q) begin
        hold_q <= 1'b0;
      end
    end else begin
      case (phase_q)
        PH_ADDR: if (addr_done) phase_q <= PH_DATA;
        PH_DATA: if (byte_queued) left_q <= left_q - ONE;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xfer_chain_seq.sv
module xfer_chain_seq
  import xfer_chain_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_stop,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic             addr_done,
  input  logic             byte_queued,
  input  logic             abort,
  output logic [1:0]       pos,
  output logic             hold
);

  logic take;
  logic busy;
  pos_t pos_next;
  pos_t pos_q;

  assign req_ready = ~busy;
  assign take      = req_valid & ~busy & ~abort;
  assign pos       = pos_q;

  xfer_chain_pos u_pos (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .stop     (req_stop),
    .abort    (abort),
    .pos_next (pos_next),
    .pos_q    (pos_q)
  );

  xfer_chain_hold #(.LEN_W(LEN_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .pos_next    (pos_next),
    .rd          (req_read),
    .len         (req_len),
    .addr_done   (addr_done),
    .byte_queued (byte_queued),
    .abort       (abort),
    .hold_q      (hold),
    .busy_q      (busy)
  );

endmodule

// File: rtl/xfer_chain_chk.sv
module xfer_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_stop,
  input logic       abort,
  input logic [1:0] pos,
  input logic       hold
);

  logic acc;
  assign acc = req_valid && req_ready && !abort;

  // R5
  pos_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pos) |-> ($past(acc) || $past(abort)));

  // R2
  alone_open_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(acc) && $past(pos) == 2'b00 && !$past(req_stop)) |-> pos == 2'b01);

  // R3
  mid_close_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(acc) && $past(pos) == 2'b10 && $past(req_stop)) |-> pos == 2'b11);

  // R4
  close_alone_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(acc) && $past(pos) == 2'b11 && $past(req_stop)) |-> pos == 2'b00);

  // R6
  hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> ($past(acc) && (pos == 2'b00 || pos == 2'b01)));

  // R9
  hold_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> ($past(abort) || pos == 2'b00 || pos == 2'b11));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (pos == 2'b00 && !hold && req_ready));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready);

endmodule

bind xfer_chain_seq xfer_chain_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_stop  (req_stop),
  .abort     (abort),
  .pos       (pos),
  .hold      (hold)
);

// File: tb/xfer_chain_seq_tb.sv
module xfer_chain_seq_tb;

  localparam int LEN_W = 8;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_stop = 1'b0;
  logic             req_read = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             addr_done = 1'b0;
  logic             byte_queued = 1'b0;
  logic             abort = 1'b0;
  logic [1:0]       pos;
  logic             hold;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] m_pos = 2'b00;
  logic       m_hold = 1'b0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_chain_seq #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_stop(req_stop), .req_read(req_read), .req_len(req_len),
    .addr_done(addr_done), .byte_queued(byte_queued), .abort(abort),
    .pos(pos), .hold(hold)
  );

  function automatic logic [1:0] step_pos(input logic [1:0] p, input logic s);
    if (p == 2'b01 || p == 2'b10) return s ? 2'b11 : 2'b10;
    return s ? 2'b00 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, {6'd0, pos}, {6'd0, m_pos});
    check(req, {7'd0, hold}, {7'd0, m_hold});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // accept one request; checks position and hold after acceptance
  task automatic issue(input logic s, input logic rd, input int len);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_stop = s; req_read = rd; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    m_pos = step_pos(m_pos, s);
    if (m_pos == 2'b00 || m_pos == 2'b01) m_hold = 1'b1;
    check("R2/R3/R4/R5 pos after accept", {6'd0, pos}, {6'd0, m_pos});
    check("R6 hold after accept", {7'd0, hold}, {7'd0, m_hold});
    check("R11 ready low while busy", {7'd0, req_ready}, 8'd0);
  endtask

  task automatic finish_msg(input logic rd, input int len, input logic extra);
    logic rel;
    rel = (m_pos == 2'b00 || m_pos == 2'b11);
    if (extra) begin
      // R12: byte before address and a request while busy are both ignored
      byte_queued = 1'b1; req_valid = 1'b1; req_stop = ~req_stop;
      @(negedge clk);
      byte_queued = 1'b0; req_valid = 1'b0;
      check_state("R11 R12 ignored pulses");
    end
    idle($urandom_range(0, 2));
    addr_done = 1'b1;
    @(negedge clk);
    addr_done = 1'b0;
    if (!rd && len > 0) begin
      check("R8 hold kept until bytes queued", {7'd0, hold}, {7'd0, m_hold});
      for (int b = 0; b < len; b++) begin
        idle($urandom_range(0, 2));
        byte_queued = 1'b1;
        @(negedge clk);
        byte_queued = 1'b0;
      end
    end
    if (rel) m_hold = 1'b0;
    if (rd) check("R7 read release", {7'd0, hold}, {7'd0, m_hold});
    else if (rel) check("R8 write release", {7'd0, hold}, {7'd0, m_hold});
    else check("R9 hold unchanged", {7'd0, hold}, {7'd0, m_hold});
    check("R11 ready after end", {7'd0, req_ready}, 8'd1);
  endtask

  task automatic do_abort();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    m_pos = 2'b00; m_hold = 1'b0;
    check_state("R10 abort");
    check("R10 ready after abort", {7'd0, req_ready}, 8'd1);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 reset");
    check("R1 ready", {7'd0, req_ready}, 8'd1);

    // R12: engine pulses while idle do nothing
    addr_done = 1'b1; byte_queued = 1'b1;
    @(negedge clk);
    addr_done = 1'b0; byte_queued = 1'b0;
    check_state("R12 idle pulses");

    // directed full chain: open, two middles, close
    issue(1'b0, 1'b0, 2); finish_msg(1'b0, 2, 1'b1);
    issue(1'b0, 1'b1, 1); finish_msg(1'b1, 1, 1'b0);
    issue(1'b0, 1'b0, 0); finish_msg(1'b0, 0, 1'b0);
    issue(1'b1, 1'b0, 3); finish_msg(1'b0, 3, 1'b0);
    // R4: close followed by standalone read
    issue(1'b1, 1'b1, 2); finish_msg(1'b1, 2, 1'b0);
    // R12: idle pulses with hold high after chain-open
    issue(1'b0, 1'b1, 1); finish_msg(1'b1, 1, 1'b0);
    addr_done = 1'b1; @(negedge clk); addr_done = 1'b0;
    check_state("R12 idle pulse keeps hold");
    // R10: abort mid-message
    issue(1'b0, 1'b0, 4);
    do_abort();

    for (int k = 0; k < 120; k++) begin
      logic s, rd;
      int len;
      s = ($urandom_range(0, 9) < 4);
      rd = $urandom_range(0, 1);
      len = $urandom_range(0, 5);
      issue(s, rd, len);
      if ($urandom_range(0, 19) == 0) do_abort();
      else finish_msg(rd, len, $urandom_range(0, 5) == 0);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule